// File: doc/BRIEF.md
# Target Data-Phase Latency Watchdog

This block sits beside the target side of a host bus interface and times how long the local logic takes to answer each data phase of an access. An access opens on the clock edge where the transaction frame is first seen high. While the frame stays high, the watchdog counts the edges on which the host still has a phase pending (local attention high) and local ready has not yet been given. If the local side does not answer within the allowed number of edges, the watchdog raises a stop request. The bus interface turns that request into a retry or a disconnect, so that a slow local side cannot hold the bus.

The first data phase of an access gets a long budget (default 16 edges). Every later phase of a burst gets a shorter budget (default 8 edges). The counter reloads after each completed phase. Once a stop request is raised, it stays high until the frame drops. Two status flags tell a first-phase retry apart from a later-phase disconnect. All pins are plain level control and status signals. The block carries no data, so it has no valid/ready stream edge and applies no back-pressure.

Top module: `phase_latency_watchdog`

## Requirements
- R1: While reset (rst_n low) is applied, and after it is released, busy, stop_req, retry_flag, disc_flag and phase_first are all 0 until an access starts.
- R2: When the block is idle and frame is sampled 1 on a clock edge, an access starts on that edge. Ready on that same edge is not counted. From the next cycle, busy is 1 and phase_first is 1.
- R3: In the first phase, attention held high with no ready raises stop_req in the cycle after the FIRST_BUDGET-th edge (16 by default) that follows the start edge. Earlier edges leave it low. This covers single-phase accesses as well.
- R4: An edge with frame, attention and ready all 1 completes the current phase. phase_first goes to 0, and the next phase times out after LATER_BUDGET (8 by default) edges with attention high and no ready.
- R5: Ready sampled together with attention on any edge up to and including the deadline edge completes the phase, and no stop request follows.
- R6: Edges on which attention is 0 neither advance the budget nor complete a phase. Ready is ignored on those edges.
- R7: Once stop_req is 1, it stays 1 while frame stays 1. The first edge with frame 0 returns the block to idle: busy and stop_req go to 0 in the next cycle.
- R8: While stop_req is 1, exactly one flag is 1: retry_flag if the timeout hit the first phase, disc_flag if it hit a later phase. Both flags are 0 whenever stop_req is 0.
- R9: An edge with frame 0 during an access that has no stop request ends the access. busy goes to 0 in the next cycle and no stop request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame | input | 1 | Transaction frame, 1 while an access is in progress |
| attn | input | 1 | Local attention: 1 while the host has a data phase pending |
| rdy | input | 1 | Local ready: completes the pending phase when sampled with attn |
| busy | output | 1 | An access is being tracked |
| stop_req | output | 1 | Request the bus interface to stop (retry or disconnect) |
| retry_flag | output | 1 | Stop was caused by a first-phase timeout |
| disc_flag | output | 1 | Stop was caused by a later-phase timeout |
| phase_first | output | 1 | The current phase is the first of the access |

## Verification
A budget counter loaded with the wrong value, or one that steps while attention is low, shows up as a stop request that rises one or more cycles early or late relative to the deadline edge. The reference model catches this on the first cycle of disagreement. A phase-tracking bit that is stuck or mis-set shows on phase_first right after the completing edge. Inside a stop, it shows as the wrong one of the two flags. A control state that fails to leave stop or an access shows as busy or stop_req still high one cycle after frame is sampled low.

// File: rtl/plw_pkg.sv
package plw_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_STOP = 2'd2
  } wd_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/plw_budget_sel.sv
module plw_budget_sel #(
  parameter int unsigned FIRST_BUDGET = 16,
  parameter int unsigned LATER_BUDGET = 8,
  parameter int unsigned CNT_W        = 5
) (
  input  logic             use_first,
  output logic [CNT_W-1:0] budget
);
  localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(FIRST_BUDGET);
  localparam logic [CNT_W-1:0] LATER_V = CNT_W'(LATER_BUDGET);

  generate
    if (FIRST_BUDGET == LATER_BUDGET) begin : g_same
      logic unused_sel;
      assign unused_sel = use_first;
      assign budget     = FIRST_V;
    end else begin : g_mux
      assign budget = use_first ? FIRST_V : LATER_V;
    end
  endgenerate
endmodule

// File: rtl/plw_phase_timer.sv
module plw_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             at_limit
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (step && remain_q > CNT_W'(1)) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  // Last edge of the budget: a further unanswered edge is a timeout.
  assign at_limit = (remain_q <= CNT_W'(1));
endmodule

// File: rtl/plw_ctrl.sv
module plw_ctrl
  import plw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic attn,
  input  logic rdy,
  input  logic at_limit,
  output logic tmr_load,
  output logic tmr_use_first,
  output logic tmr_step,
  output logic busy,
  output logic stop_req,
  output logic retry_flag,
  output logic disc_flag,
  output logic phase_first
);
  wd_state_e state_q, state_d;
  logic      first_q, first_d;
  logic      retry_q, retry_d;
  logic      disc_q,  disc_d;
  logic      done_ph, pend_ph;

  assign done_ph = frame && attn && rdy;
  assign pend_ph = frame && attn && !rdy;

  always_comb begin
    state_d       = state_q;
    first_d       = first_q;
    retry_d       = retry_q;
    disc_d        = disc_q;
    tmr_load      = 1'b0;
    tmr_use_first = 1'b0;
    tmr_step      = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (frame) begin
          state_d       = WD_RUN;
          first_d       = 1'b1;
          tmr_load      = 1'b1;
          tmr_use_first = 1'b1;
        end
      end
      WD_RUN: begin
        if (!frame) begin
          state_d = WD_IDLE;
          first_d = 1'b0;
        end else if (done_ph) begin
          first_d  = 1'b0;
          tmr_load = 1'b1;
        end else if (pend_ph) begin
          if (at_limit) begin
            state_d = WD_STOP;
            retry_d = first_q;
            disc_d  = !first_q;
          end else begin
            tmr_step = 1'b1;
          end
        end
      end
      WD_STOP: begin
        if (!frame) begin
          state_d = WD_IDLE;
          first_d = 1'b0;
          retry_d = 1'b0;
          disc_d  = 1'b0;
        end
      end
      default: begin
        state_d = WD_IDLE;
        first_d = 1'b0;
        retry_d = 1'b0;
        disc_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      first_q <= 1'b0;
      retry_q <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      retry_q <= retry_d;
      disc_q  <= disc_d;
    end
  end

  assign busy        = (state_q != WD_IDLE);
  assign stop_req    = (state_q == WD_STOP);
  assign retry_flag  = retry_q;
  assign disc_flag   = disc_q;
  assign phase_first = first_q;
endmodule

// File: rtl/phase_latency_watchdog.sv
module phase_latency_watchdog #(
  parameter int unsigned FIRST_BUDGET = 16,
  parameter int unsigned LATER_BUDGET = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic attn,
  input  logic rdy,
  output logic busy,
  output logic stop_req,
  output logic retry_flag,
  output logic disc_flag,
  output logic phase_first
);
  localparam int unsigned MAX_BUDGET = plw_pkg::max_u(FIRST_BUDGET, LATER_BUDGET);
  localparam int unsigned CNT_W      = $clog2(MAX_BUDGET + 1);

  logic             tmr_load, tmr_use_first, tmr_step, at_limit;
  logic [CNT_W-1:0] budget;

  plw_budget_sel #(
    .FIRST_BUDGET(FIRST_BUDGET),
    .LATER_BUDGET(LATER_BUDGET),
    .CNT_W       (CNT_W)
  ) u_budget (
    .use_first(tmr_use_first),
    .budget   (budget)
  );

  plw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(budget),
    .step    (tmr_step),
    .at_limit(at_limit)
  );

  plw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame        (frame),
    .attn         (attn),
    .rdy          (rdy),
    .at_limit     (at_limit),
    .tmr_load     (tmr_load),
    .tmr_use_first(tmr_use_first),
    .tmr_step     (tmr_step),
    .busy         (busy),
    .stop_req     (stop_req),
    .retry_flag   (retry_flag),
    .disc_flag    (disc_flag),
    .phase_first  (phase_first)
  );
endmodule

// File: rtl/plw_checker.sv
module plw_checker (
  input logic clk,
  input logic rst_n,
  input logic frame,
  input logic attn,
  input logic rdy,
  input logic busy,
  input logic stop_req,
  input logic retry_flag,
  input logic disc_flag,
  input logic phase_first
);
  // R1
  stop_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> busy);

  // R2
  access_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame) |=> (busy && phase_first && !stop_req));

  // R4
  phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_req && frame && attn && rdy) |=> (!phase_first && !stop_req));

  // R6
  no_idle_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_req && frame && !attn) |=> (!stop_req && $stable(phase_first)));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && frame) |=> stop_req);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !frame) |=> (!busy && !stop_req));

  // R8
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> ($countones({retry_flag, disc_flag}) == 1));

  // R8
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |-> (!retry_flag && !disc_flag));

  // R9
  access_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_req && !frame) |=> (!busy && !stop_req));
endmodule

bind phase_latency_watchdog plw_checker u_plw_checker (.*);

// File: tb/phase_latency_watchdog_bench.sv
module phase_latency_watchdog_bench;
  localparam int FIRST_B = 16;
  localparam int LATER_B = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 1'b0, attn = 1'b0, rdy = 1'b0;
  logic busy, stop_req, retry_flag, disc_flag, phase_first;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // Reference model state
  int m_state = 0;   // 0 idle, 1 running, 2 stopped
  int m_left  = 0;
  bit m_first = 1'b0, m_retry = 1'b0, m_disc = 1'b0;

  always #4 clk = ~clk;

  phase_latency_watchdog #(.FIRST_BUDGET(FIRST_B), .LATER_BUDGET(LATER_B)) u_phase_latency_watchdog (
    .clk(clk), .rst_n(rst_n), .frame(frame), .attn(attn), .rdy(rdy),
    .busy(busy), .stop_req(stop_req), .retry_flag(retry_flag),
    .disc_flag(disc_flag), .phase_first(phase_first)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_first = 0; m_retry = 0; m_disc = 0;
    end else begin
      case (m_state)
        0: if (frame) begin m_state = 1; m_left = FIRST_B; m_first = 1; end
        1: begin
          if (!frame) begin m_state = 0; m_first = 0; end
          else if (attn && rdy) begin m_first = 0; m_left = LATER_B; end
          else if (attn) begin
            if (m_left <= 1) begin m_state = 2; m_retry = m_first; m_disc = !m_first; end
            else m_left--;
          end
        end
        default: if (!frame) begin m_state = 0; m_first = 0; m_retry = 0; m_disc = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_model();
    chk(busy == (m_state != 0), "R2 busy", busy, m_state != 0);
    chk(stop_req == (m_state == 2), "R3 stop_req", stop_req, m_state == 2);
    chk(retry_flag == m_retry, "R8 retry_flag", retry_flag, m_retry);
    chk(disc_flag == m_disc, "R8 disc_flag", disc_flag, m_disc);
    chk(phase_first == m_first, "R4 phase_first", phase_first, m_first);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk(!busy && !stop_req && !retry_flag && !disc_flag && !phase_first, "R1 in reset", stop_req, 0);
    rst_n = 1'b1;
    tick();
    chk(!busy && !stop_req && !phase_first, "R1 after release", busy, 0);

    // R2/R3/R7/R8: single phase never answered
    frame = 1; attn = 1; rdy = 1;
    tick();                        // start edge, ready not counted
    rdy = 0;
    chk(busy && phase_first, "R2 start", busy, 1);
    ticks(FIRST_B - 1);
    chk(!stop_req, "R3 before deadline", stop_req, 0);
    tick();
    chk(stop_req && retry_flag && !disc_flag, "R3 R8 first timeout", stop_req, 1);
    ticks(3);
    chk(stop_req, "R7 hold", stop_req, 1);
    frame = 0; attn = 0;
    tick();
    chk(!stop_req && !busy && !retry_flag, "R7 release", busy, 0);

    // R5/R4/R8: ready on the deadline edge, then later phase times out
    frame = 1; attn = 1;
    tick();
    ticks(FIRST_B - 1);
    rdy = 1;
    tick();
    rdy = 0;
    chk(!stop_req && !phase_first, "R5 ready at deadline", stop_req, 0);
    ticks(LATER_B - 1);
    chk(!stop_req, "R4 before later deadline", stop_req, 0);
    tick();
    chk(stop_req && disc_flag && !retry_flag, "R4 R8 later timeout", disc_flag, 1);
    frame = 0; attn = 0;
    tick();

    // R6: attention low pauses the budget and ignores ready
    frame = 1; attn = 1;
    tick();
    attn = 0; rdy = 1;
    ticks(30);
    chk(!stop_req && phase_first, "R6 ready ignored", phase_first, 1);
    attn = 1; rdy = 0;
    ticks(FIRST_B - 1);
    chk(!stop_req, "R6 budget paused", stop_req, 0);
    tick();
    chk(stop_req && retry_flag, "R6 timeout after pause", stop_req, 1);
    frame = 0; attn = 0;
    tick();

    // R9: burst ends normally
    frame = 1; attn = 1;
    tick();
    for (int p = 0; p < 5; p++) begin
      ticks(3); rdy = 1; tick(); rdy = 0;
    end
    chk(!stop_req && !phase_first && busy, "R5 burst phases", busy, 1);
    frame = 0; attn = 0;
    tick();
    chk(!busy && !stop_req, "R9 end of access", busy, 0);

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) frame = ~frame;
      attn = ($urandom_range(0, 9) < 7);
      rdy  = ($urandom_range(0, 19) == 0);
      tick();
    end

    // R1: reset in the middle of an access
    frame = 1; attn = 1; rdy = 0;
    ticks(4);
    rst_n = 0;
    tick();
    chk(!busy && !stop_req && !phase_first, "R1 mid-access reset", busy, 0);
    rst_n = 1; frame = 0;
    tick();
    finish_run();
  end
endmodule